// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane RAM

A true dual-port static memory of 16-bit words with two fully independent ports, A and B. Each port has its own clock and reset and registers its address, write data, chip enables, byte selects and read/write strobe on the rising edge. Either port may read or write any word, including the word the other port is touching in the same cycle. Each port also has a static mode input. In flow-through mode, read data appears in the cycle after the edge that captured the address. In pipelined mode it appears one clock later. The output enable acts without a clock.

Instead of tri-state pins, each port returns a data bus plus one drive flag per byte lane. A byte that is not driven reads as zero on the bus. Each port's clocked control is a small state register holding the captured operation. There are three states: OP_IDLE (port deselected), OP_READ (selected with the strobe high) and OP_WRITE (selected with the strobe low). The next state is chosen on every edge from the inputs alone:
- a deselect takes any state to OP_IDLE;
- a selected read takes any state to OP_READ;
- a selected write takes any state to OP_WRITE.

A second stage copies the first on each edge. It feeds the drive logic in pipelined mode.

Top module: `dplr_ram`

## Requirements
- R1: A port is selected only when `ce0_n`=0 and `ce1`=1. In any other combination that edge writes nothing, and in flow-through mode neither byte is driven after it.
- R2: With the port selected and `we_n`=0, the edge writes bits 15:8 when `ub_n`=0 and bits 7:0 when `lb_n`=0. A byte whose select is 1 keeps its old contents.
- R3: With `pipe`=0, a read captured at edge k drives the word stored at that address before edge k, from just after edge k until edge k+1.
- R4: With `pipe`=1, a read captured at edge k is driven only after edge k+1. The output just after edge k still reflects the operation captured one edge earlier.
- R5: In both modes, the drive flag of a byte after edge k follows that byte's select as captured at edge k (`drv_hi` needs `ub_n`=0, `drv_lo` needs `lb_n`=0). An undriven byte reads 0 on `rdata`.
- R6: With `pipe`=1, chip enables pass through two stages. A deselect captured at edge k ends the drive only after edge k+1, so the output one cycle after a deselect still carries the earlier read.
- R7: `oe_n`=1 clears both drive flags and zeroes `rdata` at once, with no clock edge. Returning it to 0 restores the clocked output state, again with no edge.
- R8: A word written by one port is read back by the other port. A read at the same edge as the other port's write to the same word returns the value held before that write.
- R9: While reset is asserted and after it is released, with the port deselected, both drive flags are 0 and `rdata` is 0.
- R10: A write cycle drives neither byte: in flow-through mode both flags are 0 after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A reset, active low |
| a_pipe | input | 1 | Port A mode: 1 pipelined, 0 flow-through (static) |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_ub_n | input | 1 | Port A upper byte (15:8) select, active low |
| a_lb_n | input | 1 | Port A lower byte (7:0) select, active low |
| a_we_n | input | 1 | Port A strobe: 0 write, 1 read |
| a_oe_n | input | 1 | Port A output enable, active low, unclocked |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, zero in undriven bytes |
| a_drv_hi | output | 1 | Port A drives bits 15:8 |
| a_drv_lo | output | 1 | Port A drives bits 7:0 |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B reset, active low |
| b_pipe | input | 1 | Port B mode: 1 pipelined, 0 flow-through (static) |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_ub_n | input | 1 | Port B upper byte select, active low |
| b_lb_n | input | 1 | Port B lower byte select, active low |
| b_we_n | input | 1 | Port B strobe: 0 write, 1 read |
| b_oe_n | input | 1 | Port B output enable, active low, unclocked |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, zero in undriven bytes |
| b_drv_hi | output | 1 | Port B drives bits 15:8 |
| b_drv_lo | output | 1 | Port B drives bits 7:0 |

## Verification
The hardest case to reach from the ports is in pipelined mode, where the two control paths have different depths. There, a deselect and a byte-select change must land on consecutive edges so that the output mixes the old chip-enable state with the new byte selects. The stimulus does this with a read followed by a cycle that deselects the port but keeps one byte select low. It checks that the earlier read is still driven, in that lane only. The same-edge collision is reached by driving both ports on one shared clock, with port A writing a word while port B reads it, and checking that the old value comes back before the new one appears.

// File: rtl/dplr_pkg.sv
`timescale 1ns/1ps
package dplr_pkg;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;
endpackage

// File: rtl/dplr_bank.sv
`timescale 1ns/1ps
module dplr_bank
    import dplr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_lane,
    input  logic [AW-1:0]    wr_addr,
    input  word_t            wr_word,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output word_t            rd_word_a,
    output word_t            rd_word_b
);
    // Single-writer bank; contents start at zero so the XOR pairing is defined.
    word_t cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '0;
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_lane[l]) cells[wr_addr][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
        end
    end

    assign rd_word_a = cells[rd_addr_a];
    assign rd_word_b = cells[rd_addr_b];
endmodule

// File: rtl/dplr_port.sv
`timescale 1ns/1ps
module dplr_port
    import dplr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_mode,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ub_n,
    input  logic             lb_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  word_t            mem_word,
    output logic [LANES-1:0] wr_lane,
    output word_t            rdata,
    output logic             drv_hi,
    output logic             drv_lo
);
    port_op_e op_next, op_s1, op_s2, op_out;
    logic     ub_s1, lb_s1;
    logic     sel_now;
    word_t    flow_q, pipe_q, word_out;

    assign sel_now = !ce0_n && ce1;

    // Next-state decode from the inputs presented at this edge.
    always_comb begin
        unique case ({sel_now, we_n})
            2'b10:   op_next = OP_WRITE;
            2'b11:   op_next = OP_READ;
            default: op_next = OP_IDLE;
        endcase
    end

    // State register: stage 1 is the captured operation, stage 2 its copy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_s1 <= OP_IDLE;
            op_s2 <= OP_IDLE;
            ub_s1 <= 1'b1;
            lb_s1 <= 1'b1;
        end else begin
            op_s1 <= op_next;
            op_s2 <= op_s1;
            ub_s1 <= ub_n;
            lb_s1 <= lb_n;
        end
    end

    // Read data path: sampled word, then one further stage for pipelined mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q <= '0;
            pipe_q <= '0;
        end else begin
            flow_q <= mem_word;
            pipe_q <= flow_q;
        end
    end

    assign wr_lane = (op_next == OP_WRITE) ? {!ub_n, !lb_n} : '0;

    // Output process: mode picks the chip-enable depth; byte selects stay single.
    always_comb begin
        op_out   = pipe_mode ? op_s2 : op_s1;
        word_out = pipe_mode ? pipe_q : flow_q;
        drv_hi   = !oe_n && (op_out == OP_READ) && !ub_s1;
        drv_lo   = !oe_n && (op_out == OP_READ) && !lb_s1;
        rdata    = {drv_hi ? word_out[DATA_W-1:LANE_W] : {LANE_W{1'b0}},
                    drv_lo ? word_out[LANE_W-1:0]      : {LANE_W{1'b0}}};
    end

    a_r1_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !sel_now) |=> (pipe_mode || (!drv_hi && !drv_lo)));

    a_r6_pipe_deselect_two: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !sel_now) |=> ##1 (!pipe_mode || (!drv_hi && !drv_lo)));

    a_r5_upper_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |=> !drv_hi);

    a_r5_lower_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |=> !drv_lo);

    a_r7_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drv_hi && !drv_lo && rdata == '0));

    a_r10_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && sel_now && !we_n) |=> (pipe_mode || (!drv_hi && !drv_lo)));
endmodule

// File: rtl/dplr_ram.sv
`timescale 1ns/1ps
module dplr_ram
    import dplr_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          a_clk,
    input  logic          a_rst_n,
    input  logic          a_pipe,
    input  logic          a_ce0_n,
    input  logic          a_ce1,
    input  logic          a_ub_n,
    input  logic          a_lb_n,
    input  logic          a_we_n,
    input  logic          a_oe_n,
    input  logic [AW-1:0] a_addr,
    input  logic [15:0]   a_wdata,
    output logic [15:0]   a_rdata,
    output logic          a_drv_hi,
    output logic          a_drv_lo,
    input  logic          b_clk,
    input  logic          b_rst_n,
    input  logic          b_pipe,
    input  logic          b_ce0_n,
    input  logic          b_ce1,
    input  logic          b_ub_n,
    input  logic          b_lb_n,
    input  logic          b_we_n,
    input  logic          b_oe_n,
    input  logic [AW-1:0] b_addr,
    input  logic [15:0]   b_wdata,
    output logic [15:0]   b_rdata,
    output logic          b_drv_hi,
    output logic          b_drv_lo
);
    // Each bank has one writer; a word's value is the XOR of both banks.
    word_t            ka_at_a, ka_at_b, kb_at_a, kb_at_b;
    word_t            a_word, b_word;
    logic [LANES-1:0] a_lane, b_lane;

    assign a_word = ka_at_a ^ kb_at_a;
    assign b_word = ka_at_b ^ kb_at_b;

    dplr_bank #(.DEPTH(DEPTH), .AW(AW)) bank_a_i (
        .clk       (a_clk),
        .wr_lane   (a_lane),
        .wr_addr   (a_addr),
        .wr_word   (a_wdata ^ kb_at_a),
        .rd_addr_a (a_addr),
        .rd_addr_b (b_addr),
        .rd_word_a (ka_at_a),
        .rd_word_b (ka_at_b)
    );

    dplr_bank #(.DEPTH(DEPTH), .AW(AW)) bank_b_i (
        .clk       (b_clk),
        .wr_lane   (b_lane),
        .wr_addr   (b_addr),
        .wr_word   (b_wdata ^ ka_at_b),
        .rd_addr_a (a_addr),
        .rd_addr_b (b_addr),
        .rd_word_a (kb_at_a),
        .rd_word_b (kb_at_b)
    );

    dplr_port port_a_i (
        .clk       (a_clk),
        .rst_n     (a_rst_n),
        .pipe_mode (a_pipe),
        .ce0_n     (a_ce0_n),
        .ce1       (a_ce1),
        .ub_n      (a_ub_n),
        .lb_n      (a_lb_n),
        .we_n      (a_we_n),
        .oe_n      (a_oe_n),
        .mem_word  (a_word),
        .wr_lane   (a_lane),
        .rdata     (a_rdata),
        .drv_hi    (a_drv_hi),
        .drv_lo    (a_drv_lo)
    );

    dplr_port port_b_i (
        .clk       (b_clk),
        .rst_n     (b_rst_n),
        .pipe_mode (b_pipe),
        .ce0_n     (b_ce0_n),
        .ce1       (b_ce1),
        .ub_n      (b_ub_n),
        .lb_n      (b_lb_n),
        .we_n      (b_we_n),
        .oe_n      (b_oe_n),
        .mem_word  (b_word),
        .wr_lane   (b_lane),
        .rdata     (b_rdata),
        .drv_hi    (b_drv_hi),
        .drv_lo    (b_drv_lo)
    );
endmodule

// File: tb/dplr_ram_tb.sv
`timescale 1ns/1ps
module dplr_ram_tb_top;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          a_rst_n, a_pipe, a_ce0_n, a_ce1, a_ub_n, a_lb_n, a_we_n, a_oe_n;
    logic [AW-1:0] a_addr;
    logic [15:0]   a_wdata, a_rdata;
    logic          a_drv_hi, a_drv_lo;
    logic          b_rst_n, b_pipe, b_ce0_n, b_ce1, b_ub_n, b_lb_n, b_we_n, b_oe_n;
    logic [AW-1:0] b_addr;
    logic [15:0]   b_wdata, b_rdata;
    logic          b_drv_hi, b_drv_lo;

    int n_cmp = 0;
    int n_bad = 0;

    dplr_ram #(.DEPTH(DEPTH)) dut_i (
        .a_clk(clk), .a_rst_n(a_rst_n), .a_pipe(a_pipe), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1),
        .a_ub_n(a_ub_n), .a_lb_n(a_lb_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drv_hi(a_drv_hi), .a_drv_lo(a_drv_lo),
        .b_clk(clk), .b_rst_n(b_rst_n), .b_pipe(b_pipe), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1),
        .b_ub_n(b_ub_n), .b_lb_n(b_lb_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drv_hi(b_drv_hi), .b_drv_lo(b_drv_lo)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_a(input logic ce0_n, input logic ce1, input logic ub_n, input logic lb_n,
                         input logic we_n, input logic [AW-1:0] addr, input logic [15:0] wd);
        a_ce0_n = ce0_n; a_ce1 = ce1; a_ub_n = ub_n; a_lb_n = lb_n;
        a_we_n = we_n; a_addr = addr; a_wdata = wd;
    endtask

    task automatic set_b(input logic ce0_n, input logic ce1, input logic ub_n, input logic lb_n,
                         input logic we_n, input logic [AW-1:0] addr, input logic [15:0] wd);
        b_ce0_n = ce0_n; b_ce1 = ce1; b_ub_n = ub_n; b_lb_n = lb_n;
        b_we_n = we_n; b_addr = addr; b_wdata = wd;
    endtask

    task automatic t_reset_state();
        a_rst_n = 1'b0; b_rst_n = 1'b0;
        a_pipe = 1'b0; b_pipe = 1'b1; a_oe_n = 1'b0; b_oe_n = 1'b0;
        set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        repeat (3) tick();
        chk("R9 a drive in reset", {14'd0, a_drv_hi, a_drv_lo}, 16'd0);
        chk("R9 b rdata in reset", b_rdata, 16'd0);
        a_rst_n = 1'b1; b_rst_n = 1'b1;
        repeat (2) tick();
        chk("R9 a after reset", {a_rdata[15:2], a_drv_hi, a_drv_lo}, 16'd0);
        chk("R9 b after reset", {b_rdata[15:2], b_drv_hi, b_drv_lo}, 16'd0);
    endtask

    task automatic t_write_lanes();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5, 16'hA1B2);
        tick();
        chk("R10 flow write drives nothing", {14'd0, a_drv_hi, a_drv_lo}, 16'd0);
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 16'h3CFF);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R3 flow read data after its edge", a_rdata, 16'h3CB2);
        chk("R2 lower lane kept, drive flags", {14'd0, a_drv_hi, a_drv_lo}, 16'd3);
        set_a(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 16'h77EE);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R2 upper lane kept on lower write", a_rdata, 16'h3CEE);
    endtask

    task automatic t_select();
        set_a(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R1 ce1 low no drive", {a_rdata[15:2], a_drv_hi, a_drv_lo}, 16'd0);
        set_a(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd5, 16'hFFFF);
        tick();
        chk("R1 ce0_n high no drive", {a_rdata[15:2], a_drv_hi, a_drv_lo}, 16'd0);
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R1 deselected write ignored", a_rdata, 16'h3CEE);
        set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R5 flow lower select off", {a_rdata[15:2], a_drv_hi, a_drv_lo}, {8'h3C, 6'd0, 2'b10});
    endtask

    task automatic t_oe();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        a_oe_n = 1'b1;
        #1;
        chk("R7 oe high blocks at once", {a_rdata[15:2], a_drv_hi, a_drv_lo}, 16'd0);
        a_oe_n = 1'b0;
        #1;
        chk("R7 oe low restores without edge", a_rdata, 16'h3CEE);
        set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        tick();
    endtask

    task automatic t_pipe();
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R4 pipe no data one edge after", {b_rdata[15:2], b_drv_hi, b_drv_lo}, 16'd0);
        set_b(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R4 pipe data two edges after", b_rdata, 16'h3CEE);
        chk("R6 deselect still driving", {14'd0, b_drv_hi, b_drv_lo}, 16'd3);
        tick();
        chk("R6 deselect ends after second edge", {b_rdata[15:2], b_drv_hi, b_drv_lo}, 16'd0);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        set_b(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 16'h0000);
        tick();
        chk("R5 pipe byte select single stage", {b_rdata[15:2], b_drv_hi, b_drv_lo}, {8'h00, 6'h3B, 2'b01});
        set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        repeat (2) tick();
    endtask

    task automatic t_collide();
        b_pipe = 1'b0;
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 16'h1111);
        tick();
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 16'h2222);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd7, 16'h0000);
        tick();
        chk("R8 same-edge read returns old", b_rdata, 16'h1111);
        set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        tick();
        chk("R8 later read sees new", b_rdata, 16'h2222);
        set_b(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd9, 16'h5A5A);
        tick();
        set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        set_a(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd9, 16'h0000);
        tick();
        chk("R8 B write read by A", a_rdata, 16'h5A5A);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL all requirements: watchdog expired, actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_write_lanes();
        t_select();
        t_oe();
        t_pipe();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule